// File: doc/BRIEF.md
# DDR SDRAM Write Burst Sequencer

This block sits on the controller side of a double-data-rate SDRAM link and performs one complete write transaction per request. It opens a row with an activate command and waits a set row-to-column delay, filling the gap with no-operation commands. It then issues a write command that carries the bank and starting column. One clock cycle later it drives the data burst on the data lines, together with a source-synchronous strobe and a per-beat byte mask. The strobe has a low preamble before its first rising edge and a low postamble after the burst, and is then released.

The block runs on an internal clock at twice the memory clock rate, so each internal tick is one half of a memory clock cycle. It outputs the memory clock level as `ck` so that commands line up with its high half. The request carries a bank, a row, a column, a burst-length selector, up to eight data words and eight mask bits. The burst length is 2, 4 or 8 beats and is chosen per request. The block accepts a request only while idle and during the low half of the memory clock. It raises a one-tick completion pulse after the postamble.

Top module: `ddr_wr_seq`

## Requirements
- R1: A request is taken only when `req_ready` is high, which is only while idle and `ck` is low. On the next tick the activate command (`cmd_rcw` = 3'b011) appears with the row on `addr` and the bank on `ba`, and it is held for two ticks. `req_ready` stays low until the sequence has finished.
- R2: No-operation commands fill the cycles between activate and write. The write command starts exactly `TRCD` memory clock cycles (2*`TRCD` ticks) after the activate and is held for two ticks. During the write, the column is zero-extended on `addr` and the bank is on `ba`.
- R3: `cmd_rcw` is {row strobe, column strobe, write enable}, all active low: activate 3'b011, write 3'b100, no-operation 3'b111. A command always begins on a tick with `ck` high.
- R4: `req_bl_sel` picks the burst length when the request is accepted: 2'b00 gives 2 beats, 2'b01 gives 4 beats, and 2'b10 or 2'b11 give 8 beats. `dq_oe` is high for exactly that many consecutive ticks.
- R5: The first beat appears on `dq` two ticks (one memory clock) after the first tick of the write command. Beat k is `req_data[k*8 +: 8]`, and beats follow on consecutive ticks.
- R6: `dm` carries mask bit `req_mask[k]` in the same tick as beat k.
- R7: While data is driven, `dqs` is high on even-numbered beats and low on odd-numbered beats, so each beat has its own strobe edge.
- R8: `dqs_oe` rises one tick before the first beat, with `dqs` low and `dq_oe` low (preamble).
- R9: In the tick after the last beat, `dqs_oe` is high, `dqs` is low and `dq_oe` is low (postamble). In the tick after that, `dqs_oe` is low.
- R10: Outside preamble, burst and postamble, `dqs_oe` and `dq_oe` are low. When not driven, `dq`, `dm` and `dqs` read 0. During no-operation commands `addr` and `ba` read 0. Reset leaves the block idle with a no-operation command.
- R11: `done` is high for exactly one tick, right after the postamble tick. `req_ready` returns on the second tick after `done`.
- R12: Changes to any request input while a sequence runs have no effect on that sequence's outputs, and do not start a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Internal clock at twice the memory clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this tick when valid |
| req_bank | input | BA_W | Bank of the write |
| req_row | input | ADDR_W | Row to open |
| req_col | input | COL_W | Starting column |
| req_bl_sel | input | 2 | Burst length selector |
| req_data | input | 8*DQ_W | Burst data, beat k in slice k |
| req_mask | input | 8*DM_W | Byte mask, beat k in slice k |
| ck | output | 1 | Memory clock level (high half first) |
| cmd_rcw | output | 3 | Command {row strobe, column strobe, write enable}, active low |
| addr | output | ADDR_W | Row or column address |
| ba | output | BA_W | Bank address |
| dq | output | DQ_W | Write data |
| dq_oe | output | 1 | Data output enable |
| dm | output | DM_W | Data mask |
| dqs | output | 1 | Data strobe |
| dqs_oe | output | 1 | Strobe output enable |
| done | output | 1 | One-tick completion pulse |

## Verification
The hardest situation to reach from the ports is a request whose inputs keep changing, with `req_valid` toggling, while the sequence is already running. The captured copy must hold, and no second activate may start before `req_ready` returns. The bench reaches it by scrambling every request field and the valid bit on each tick of selected random transactions. It then checks every tick of the timeline, including the strobe preamble and postamble edges, against expected values built from the original request. Directed transactions cover each burst-length code, including the 2'b11 alias for eight beats, and requests issued back to back.

// File: rtl/ddr_wr_seq_pkg.sv
package ddr_wr_seq_pkg;

  localparam int MAX_BL = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_GAP,
    ST_WR,
    ST_PRE,
    ST_BURST,
    ST_POST,
    ST_DONE
  } seq_state_t;

  localparam logic [2:0] CMD_ACT   = 3'b011;
  localparam logic [2:0] CMD_WRITE = 3'b100;
  localparam logic [2:0] CMD_NOP   = 3'b111;

  // burst length code to beat count
  function automatic logic [3:0] beats_for(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd2;
      2'b01:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  // strobe level for a given beat: high on even beats
  function automatic logic strobe_level(input logic [2:0] beat);
    return ~beat[0];
  endfunction

endpackage

// File: rtl/ddr_wr_seq_fsm.sv
module ddr_wr_seq_fsm
  import ddr_wr_seq_pkg::*;
#(
  parameter int TRCD  = 3,
  parameter int CNT_W = 4
) (
  input  logic       clk2x,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] bl_sel,
  output seq_state_t state,
  output logic [2:0] beat_idx,
  output logic       ck_q,
  output logic       req_ready,
  output logic       acc_ev,
  output logic       burst_last
);
  localparam int GAP_TICKS = 2 * (TRCD - 1);

  logic [CNT_W-1:0] cnt;
  logic [3:0]       bl_q;

  assign req_ready  = (state == ST_IDLE) && !ck_q;
  assign acc_ev     = req_ready && req_valid;
  assign burst_last = (state == ST_BURST) && (cnt == (CNT_W'(bl_q) - CNT_W'(1)));
  assign beat_idx   = cnt[2:0];

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) ck_q <= 1'b0;
    else        ck_q <= ~ck_q;
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      bl_q  <= 4'd2;
    end else begin
      case (state)
        ST_IDLE: begin
          if (acc_ev) begin
            state <= ST_ACT;
            cnt   <= '0;
            bl_q  <= beats_for(bl_sel);
          end
        end
        ST_ACT: begin
          if (cnt == CNT_W'(1)) begin
            cnt   <= '0;
            state <= (GAP_TICKS == 0) ? ST_WR : ST_GAP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (cnt == CNT_W'(GAP_TICKS - 1)) begin
            cnt   <= '0;
            state <= ST_WR;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WR: state <= ST_PRE;
        ST_PRE: begin
          state <= ST_BURST;
          cnt   <= '0;
        end
        ST_BURST: begin
          if (burst_last) begin
            state <= ST_POST;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_POST: state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr_wr_seq_capt.sv
module ddr_wr_seq_capt #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 64,
  parameter int MASK_W = 8
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              acc_ev,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_data,
  input  logic [MASK_W-1:0] req_mask,
  output logic [BA_W-1:0]   bank_q,
  output logic [ADDR_W-1:0] row_q,
  output logic [COL_W-1:0]  col_q,
  output logic [DATA_W-1:0] data_q,
  output logic [MASK_W-1:0] mask_q
);
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else if (acc_ev) begin
      bank_q <= req_bank;
      row_q  <= req_row;
      col_q  <= req_col;
      data_q <= req_data;
      mask_q <= req_mask;
    end
  end
endmodule

// File: rtl/ddr_wr_seq_cmd.sv
module ddr_wr_seq_cmd
  import ddr_wr_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10
) (
  input  seq_state_t        state,
  input  logic [BA_W-1:0]   bank_q,
  input  logic [ADDR_W-1:0] row_q,
  input  logic [COL_W-1:0]  col_q,
  output logic [2:0]        cmd_rcw,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  always_comb begin
    cmd_rcw = CMD_NOP;
    addr    = '0;
    ba      = '0;
    case (state)
      ST_ACT: begin
        cmd_rcw = CMD_ACT;
        addr    = row_q;
        ba      = bank_q;
      end
      ST_WR, ST_PRE: begin
        cmd_rcw = CMD_WRITE;
        addr    = ADDR_W'(col_q);
        ba      = bank_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_wr_seq_beat.sv
module ddr_wr_seq_beat
  import ddr_wr_seq_pkg::*;
#(
  parameter int DQ_W = 8,
  parameter int DM_W = 1
) (
  input  seq_state_t              state,
  input  logic [2:0]              beat_idx,
  input  logic [MAX_BL*DQ_W-1:0]  data_q,
  input  logic [MAX_BL*DM_W-1:0]  mask_q,
  output logic [DQ_W-1:0]         dq,
  output logic                    dq_oe,
  output logic [DM_W-1:0]         dm,
  output logic                    dqs,
  output logic                    dqs_oe
);
  logic [DQ_W-1:0] beat_dq [MAX_BL];
  logic [DM_W-1:0] beat_dm [MAX_BL];

  for (genvar g = 0; g < MAX_BL; g++) begin : g_unpack
    assign beat_dq[g] = data_q[g*DQ_W +: DQ_W];
    assign beat_dm[g] = mask_q[g*DM_W +: DM_W];
  end

  logic in_burst;
  assign in_burst = (state == ST_BURST);

  always_comb begin
    dq_oe  = in_burst;
    dq     = in_burst ? beat_dq[beat_idx] : '0;
    dm     = in_burst ? beat_dm[beat_idx] : '0;
    dqs    = in_burst && strobe_level(beat_idx);
    dqs_oe = (state == ST_PRE) || in_burst || (state == ST_POST);
  end
endmodule

// File: rtl/ddr_wr_seq.sv
module ddr_wr_seq
  import ddr_wr_seq_pkg::*;
#(
  parameter int TRCD   = 3,
  parameter int DQ_W   = 8,
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  localparam int DM_W  = DQ_W / 8,
  localparam int DATA_W = MAX_BL * DQ_W,
  localparam int MASK_W = MAX_BL * DM_W
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [1:0]        req_bl_sel,
  input  logic [DATA_W-1:0] req_data,
  input  logic [MASK_W-1:0] req_mask,
  output logic              ck,
  output logic [2:0]        cmd_rcw,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic [DQ_W-1:0]   dq,
  output logic              dq_oe,
  output logic [DM_W-1:0]   dm,
  output logic              dqs,
  output logic              dqs_oe,
  output logic              done
);
  localparam int CNT_W = $clog2(2 * TRCD + MAX_BL + 2);

  seq_state_t        state;
  logic [2:0]        beat_idx;
  logic              ck_q;
  logic              acc_ev;
  logic              burst_last;
  logic [BA_W-1:0]   bank_q;
  logic [ADDR_W-1:0] row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] data_q;
  logic [MASK_W-1:0] mask_q;

  ddr_wr_seq_fsm #(.TRCD(TRCD), .CNT_W(CNT_W)) u_fsm (
    .clk2x(clk2x), .rst_n(rst_n), .req_valid(req_valid), .bl_sel(req_bl_sel),
    .state(state), .beat_idx(beat_idx), .ck_q(ck_q), .req_ready(req_ready),
    .acc_ev(acc_ev), .burst_last(burst_last)
  );

  ddr_wr_seq_capt #(.BA_W(BA_W), .ADDR_W(ADDR_W), .COL_W(COL_W),
                    .DATA_W(DATA_W), .MASK_W(MASK_W)) u_capt (
    .clk2x(clk2x), .rst_n(rst_n), .acc_ev(acc_ev),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_data(req_data), .req_mask(req_mask),
    .bank_q(bank_q), .row_q(row_q), .col_q(col_q),
    .data_q(data_q), .mask_q(mask_q)
  );

  ddr_wr_seq_cmd #(.BA_W(BA_W), .ADDR_W(ADDR_W), .COL_W(COL_W)) u_cmd (
    .state(state), .bank_q(bank_q), .row_q(row_q), .col_q(col_q),
    .cmd_rcw(cmd_rcw), .addr(addr), .ba(ba)
  );

  ddr_wr_seq_beat #(.DQ_W(DQ_W), .DM_W(DM_W)) u_beat (
    .state(state), .beat_idx(beat_idx), .data_q(data_q), .mask_q(mask_q),
    .dq(dq), .dq_oe(dq_oe), .dm(dm), .dqs(dqs), .dqs_oe(dqs_oe)
  );

  assign ck   = ck_q;
  assign done = (state == ST_DONE);
endmodule

// File: rtl/ddr_wr_seq_chk.sv
module ddr_wr_seq_chk (
  input logic       clk2x,
  input logic       rst_n,
  input logic       req_ready,
  input logic       ck,
  input logic [2:0] cmd_rcw,
  input logic       dq_oe,
  input logic       dqs,
  input logic       dqs_oe,
  input logic       done,
  input logic       acc_ev,
  input logic       burst_last
);
  assert_accept_act_R1: assert property (@(posedge clk2x) disable iff (!rst_n)
    acc_ev |=> (cmd_rcw == 3'b011 && ck));

  assert_ready_idle_R1: assert property (@(posedge clk2x) disable iff (!rst_n)
    req_ready |-> (cmd_rcw == 3'b111 && !dqs_oe && !ck));

  assert_cmd_legal_R3: assert property (@(posedge clk2x) disable iff (!rst_n)
    (cmd_rcw == 3'b011 || cmd_rcw == 3'b100 || cmd_rcw == 3'b111));

  assert_cmd_on_ck_high_R3: assert property (@(posedge clk2x) disable iff (!rst_n)
    (cmd_rcw != $past(cmd_rcw)) |-> ck);

  assert_write_latency_R5: assert property (@(posedge clk2x) disable iff (!rst_n)
    (cmd_rcw == 3'b100 && ck) |-> ##2 (dq_oe && dqs));

  assert_preamble_R8: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(dqs_oe) |-> (!dqs && !dq_oe));

  assert_postamble_R9: assert property (@(posedge clk2x) disable iff (!rst_n)
    burst_last |=> (dqs_oe && !dqs && !dq_oe));

  assert_release_low_R9: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(dqs_oe) |-> $past(!dqs && !dq_oe));

  assert_dq_inside_strobe_R10: assert property (@(posedge clk2x) disable iff (!rst_n)
    dq_oe |-> dqs_oe);

  assert_done_single_R11: assert property (@(posedge clk2x) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_post_R11: assert property (@(posedge clk2x) disable iff (!rst_n)
    done |-> ($past(dqs_oe) && !dqs_oe));
endmodule

bind ddr_wr_seq ddr_wr_seq_chk u_chk (
  .clk2x(clk2x), .rst_n(rst_n), .req_ready(req_ready), .ck(ck),
  .cmd_rcw(cmd_rcw), .dq_oe(dq_oe), .dqs(dqs), .dqs_oe(dqs_oe),
  .done(done), .acc_ev(acc_ev), .burst_last(burst_last)
);

// File: tb/ddr_wr_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_wr_seq_tb_top;
  localparam int TRCD = 3;
  localparam int W    = 2 * TRCD;

  logic        clk2x = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [1:0]  req_bl_sel = '0;
  logic [63:0] req_data = '0;
  logic [7:0]  req_mask = '0;
  logic        ck;
  logic [2:0]  cmd_rcw;
  logic [12:0] addr;
  logic [1:0]  ba;
  logic [7:0]  dq;
  logic        dq_oe;
  logic [0:0]  dm;
  logic        dqs;
  logic        dqs_oe;
  logic        done;

  int tests = 0;
  int fails = 0;

  always #10 clk2x = ~clk2x;

  ddr_wr_seq #(.TRCD(TRCD)) dut_i (
    .clk2x(clk2x), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_bl_sel(req_bl_sel), .req_data(req_data), .req_mask(req_mask),
    .ck(ck), .cmd_rcw(cmd_rcw), .addr(addr), .ba(ba), .dq(dq), .dq_oe(dq_oe),
    .dm(dm), .dqs(dqs), .dqs_oe(dqs_oe), .done(done)
  );

  function automatic int exp_beats(input logic [1:0] sel);
    return (sel == 2'b00) ? 2 : (sel == 2'b01) ? 4 : 8;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk2x);
  endtask

  task automatic run_txn(input logic [1:0] bk, input logic [12:0] row,
                         input logic [9:0] col, input logic [1:0] sel,
                         input logic [63:0] data, input logic [7:0] mask,
                         input bit scramble);
    int bl;
    int last;
    string dtag;
    wait_ready();
    req_bank = bk; req_row = row; req_col = col; req_bl_sel = sel;
    req_data = data; req_mask = mask; req_valid = 1'b1;
    bl   = exp_beats(sel);
    last = W + 3 + bl;
    dtag = scramble ? "R12" : "R5";
    for (int t = 0; t <= last; t++) begin
      logic [2:0]  e_cmd;
      logic [12:0] e_addr;
      logic [1:0]  e_ba;
      logic        e_burst;
      int          beat;
      @(negedge clk2x);
      if (t < 2)                  begin e_cmd = 3'b011; e_addr = row; e_ba = bk; end
      else if (t < W)             begin e_cmd = 3'b111; e_addr = '0; e_ba = '0; end
      else if (t < W + 2)         begin e_cmd = 3'b100; e_addr = 13'(col); e_ba = bk; end
      else                        begin e_cmd = 3'b111; e_addr = '0; e_ba = '0; end
      beat    = t - W - 2;
      e_burst = (beat >= 0) && (beat < bl);
      chk((t < 2) ? "R1" : "R2", 64'(cmd_rcw), 64'(e_cmd));
      chk((t < 2) ? "R1" : "R2", 64'({addr, ba}), 64'({e_addr, e_ba}));
      chk("R3 ck", 64'(ck), 64'((t % 2) == 0));
      chk("R4 dq_oe", 64'(dq_oe), 64'(e_burst));
      chk(dtag, 64'(dq), e_burst ? 64'(data[beat*8 +: 8]) : 64'd0);
      chk(scramble ? "R12" : "R6", 64'(dm), e_burst ? 64'(mask[beat]) : 64'd0);
      chk("R7 dqs", 64'(dqs), 64'(e_burst && (beat % 2 == 0)));
      chk((t <= W + 1) ? "R8 dqs_oe" : (t >= W + 2 + bl) ? "R9 dqs_oe" : "R10 dqs_oe",
          64'(dqs_oe), 64'((t >= W + 1) && (t <= W + 2 + bl)));
      chk("R11 done", 64'(done), 64'(t == last));
      chk("R1 busy", 64'(req_ready), 64'd0);
      if (t == 0) req_valid = 1'b0;
      if (scramble) begin
        req_bank = 2'($urandom); req_row = 13'($urandom); req_col = 10'($urandom);
        req_bl_sel = 2'($urandom); req_data = {$urandom, $urandom};
        req_mask = 8'($urandom);
        req_valid = (t < last) ? 1'($urandom) : 1'b0;
      end
    end
    @(negedge clk2x);
    chk("R11 gap", 64'({req_ready, done, dqs_oe}), 64'd0);
    chk("R10 nop", 64'(cmd_rcw), 64'(3'b111));
    @(negedge clk2x);
    chk("R11 ready", 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk2x);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk2x);
    chk("R10 reset cmd", 64'(cmd_rcw), 64'(3'b111));
    chk("R10 reset oe", 64'({dq_oe, dqs_oe, done, dqs}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk2x);
    // directed: every burst code, including the alias 2'b11 for eight beats (R4)
    run_txn(2'd1, 13'h1abc, 10'h3ff, 2'b00, 64'h0011223344556677, 8'b0000_0010, 1'b0);
    run_txn(2'd2, 13'h0001, 10'h001, 2'b01, 64'h89abcdef01234567, 8'b0000_0101, 1'b0);
    run_txn(2'd3, 13'h1fff, 10'h155, 2'b10, 64'hfedcba9876543210, 8'b1010_0101, 1'b0);
    run_txn(2'd0, 13'h0aaa, 10'h2aa, 2'b11, 64'h1122334455667788, 8'b1000_0001, 1'b0);
    // directed: request inputs thrash during an eight-beat burst (R12)
    run_txn(2'd2, 13'h0555, 10'h0f0, 2'b10, 64'hcafef00ddeadbeef, 8'b0110_1001, 1'b1);
    for (int i = 0; i < 40; i++) begin
      run_txn(2'($urandom), 13'($urandom), 10'($urandom), 2'($urandom),
              {$urandom, $urandom}, 8'($urandom), 1'((i % 3) == 0));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule